// File: doc/BRIEF.md
# PCM Frame Alignment Counter

This block tracks where one side of a PCM serial link is inside its frame. It counts bit times on the local clock and reports the bit position within the current channel, the channel number, a strobe at each frame boundary and a flag for the framing-bit slot. A rising edge on the frame sync input pins the frame boundary. After a single such edge the counter keeps running on its own like a flywheel. Any later rising edge pulls it back onto that edge. Two frame layouts are supported. The first is a 193-bit layout: one framing bit, then 24 eight-bit channels, running at 1.544 MHz. The second is a 256-bit layout: 32 eight-bit channels with no framing bit, running at 2.048 MHz. Both give 8 kHz frames.

When the block is used on the system side, it also chooses the value sent in the framing-bit slot. The choice depends on the format of the peer (receive) side. If the peer also uses the 193-bit layout, the peer's framing bit is forwarded. If the peer uses the 256-bit layout, a constant 1 is sent. The sample data itself is held elsewhere.

Top module: `pcm_frame_align`

## Requirements
- R1: While reset is low, and until the first clock edge after reset is released, the outputs show position 0 of a 193-bit frame: frame_start=1, fbit_slot=1, chan_idx=0, bit_idx=0, fmt_active=0.
- R2: Suppose frame_sync is sampled low at clock edge k-1 and high at edge k. Then frame position 0 (frame_start=1, chan_idx=0, bit_idx=0) is presented right after edge k+1.
- R3: frame_sync held high for many cycles counts as one edge only; the frame period stays 193 or 256 cycles while the level is held.
- R4: In the 193-bit format (fmt_active=0), position 0 is the framing-bit slot, with fbit_slot=1 and chan_idx=bit_idx=0. Positions 1..192 carry channels 0..23, each with bit_idx 0..7 in order. The frame lasts 193 cycles.
- R5: In the 256-bit format (fmt_active=1), positions 0..255 carry channels 0..31, each with bit_idx 0..7. fbit_slot is never 1, and the frame lasts 256 cycles.
- R6: Without further sync edges, frame_start recurs every 193 cycles (format 0) or every 256 cycles (format 1).
- R7: A sync edge in the middle of a frame restarts the count at position 0, as timed in R2, in either format.
- R8: fmt_sel (0 = 193-bit, 1 = 256-bit) is taken into fmt_active only when a frame wraps naturally or a sync edge realigns the counter. A change in the middle of a frame leaves fmt_active and the count unchanged until then.
- R9: fbit_out is 0 outside the framing-bit slot. Inside the slot it equals peer_fbit when peer_fmt_sel=0, and it is 1 when peer_fmt_sel=1.
- R10: frame_start is 1 exactly at frame position 0: the framing-bit slot in format 0, and channel 0 bit 0 in format 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame sync; a rising edge marks the frame boundary |
| fmt_sel | input | 1 | Local format request: 0 = 193-bit, 1 = 256-bit |
| peer_fmt_sel | input | 1 | Format of the peer (receive) side |
| peer_fbit | input | 1 | Framing bit received from the peer side |
| bit_idx | output | 3 | Bit position inside the current channel |
| chan_idx | output | 5 | Current channel number, starting at 0 |
| frame_start | output | 1 | High at frame position 0 |
| fbit_slot | output | 1 | High during the framing-bit slot |
| fbit_out | output | 1 | Value to send in the framing-bit slot |
| fmt_active | output | 1 | Format the current frame uses |

## Verification
The hardest case to reach is a change of format in the middle of a frame. The new format must stay pending until a boundary, and the boundary can come from either a natural wrap or a sync edge. The stimulus changes fmt_sel partway through a 193-bit frame, lets the frame run out, and confirms that the next frame lasts 256 cycles. It then changes back while also pulsing sync, so the switch happens at the realignment instead. A behavioural model of the frame position runs alongside and is compared every clock. Directed checks also cover edge latency, a held sync level and the forwarding of the framing bit.

// File: rtl/pfa_pkg.sv
// Shared types for the PCM frame alignment counter.
// Assumes only two frame layouts exist; the enum value matches the select pin level.
package pfa_pkg;
    typedef enum logic {
        FMT_T1   = 1'b0,   // 193-bit frame with a framing-bit slot
        FMT_CEPT = 1'b1    // 256-bit frame, no framing-bit slot
    } fmt_e;
endpackage

// File: rtl/pfa_sync_edge.sv
// Rising-edge detector for the frame sync input in the local clock domain.
// Assumes frame_sync is already synchronous to clk; output is one cycle wide.
module pfa_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise
);
    logic cur_q;
    logic prev_q;

    // Keep the current and the previous sample of the sync line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= sync_in;
            prev_q <= cur_q;
        end
    end

    // A rise is a new high sample following a low one.
    always_comb rise = cur_q & ~prev_q;
endmodule

// File: rtl/pfa_frame_counter.sv
// Flywheel bit/channel counter with an optional framing-bit slot at position 0.
// Assumes a realign request restarts the frame and samples the requested format;
// a natural wrap also samples the requested format.
module pfa_frame_counter
    import pfa_pkg::*;
#(
    parameter int BITS_PER_CHAN = 8,
    parameter int T1_CHANNELS   = 24,
    parameter int CEPT_CHANNELS = 32,
    parameter int BIT_W         = 3,
    parameter int CH_W          = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             realign,
    input  fmt_e             fmt_req,
    output logic [BIT_W-1:0] bit_idx,
    output logic [CH_W-1:0]  chan_idx,
    output logic             in_fslot,
    output fmt_e             fmt_act
);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BITS_PER_CHAN - 1);
    localparam logic [CH_W-1:0]  T1_LAST   = CH_W'(T1_CHANNELS - 1);
    localparam logic [CH_W-1:0]  CEPT_LAST = CH_W'(CEPT_CHANNELS - 1);

    logic [BIT_W-1:0] bit_q, bit_n;
    logic [CH_W-1:0]  chan_q, chan_n;
    logic             fs_q, fs_n;
    fmt_e             act_q, act_n;
    logic [CH_W-1:0]  last_chan;

    // Last channel of the layout currently in use.
    always_comb last_chan = (act_q == FMT_T1) ? T1_LAST : CEPT_LAST;

    // Next position: realign, leave the F slot, wrap a channel/frame, or step.
    always_comb begin
        bit_n  = bit_q;
        chan_n = chan_q;
        fs_n   = 1'b0;
        act_n  = act_q;
        if (realign) begin
            act_n  = fmt_req;
            fs_n   = (fmt_req == FMT_T1);
            bit_n  = '0;
            chan_n = '0;
        end else if (fs_q) begin
            bit_n  = '0;
            chan_n = '0;
        end else if (bit_q == BIT_LAST) begin
            bit_n = '0;
            if (chan_q == last_chan) begin
                chan_n = '0;
                act_n  = fmt_req;
                fs_n   = (fmt_req == FMT_T1);
            end else begin
                chan_n = chan_q + 1'b1;
            end
        end else begin
            bit_n = bit_q + 1'b1;
        end
    end

    // Position state; reset lands on the F slot of a 193-bit frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            chan_q <= '0;
            fs_q   <= 1'b1;
            act_q  <= FMT_T1;
        end else begin
            bit_q  <= bit_n;
            chan_q <= chan_n;
            fs_q   <= fs_n;
            act_q  <= act_n;
        end
    end

    // Drive the position outputs straight from state.
    always_comb begin
        bit_idx  = bit_q;
        chan_idx = chan_q;
        in_fslot = fs_q;
        fmt_act  = act_q;
    end
endmodule

// File: rtl/pfa_slot_out.sv
// Decodes the frame-boundary strobe and picks the framing-bit value to send.
// Assumes the F slot only exists in the 193-bit format (counter guarantees it).
module pfa_slot_out
    import pfa_pkg::*;
#(
    parameter int BIT_W = 3,
    parameter int CH_W  = 5
) (
    input  logic [BIT_W-1:0] bit_idx,
    input  logic [CH_W-1:0]  chan_idx,
    input  logic             in_fslot,
    input  fmt_e             fmt_act,
    input  fmt_e             peer_fmt,
    input  logic             peer_fbit,
    output logic             frame_start,
    output logic             fbit_out
);
    logic cept_origin;

    // Position 0 of a 256-bit frame is channel 0, bit 0.
    always_comb cept_origin = (fmt_act == FMT_CEPT) && (bit_idx == '0) && (chan_idx == '0);

    // Boundary strobe covers both layouts.
    always_comb frame_start = in_fslot | cept_origin;

    // Forward the peer F-bit for like formats, force 1 when the peer has none.
    always_comb fbit_out = in_fslot & ((peer_fmt == FMT_T1) ? peer_fbit : 1'b1);
endmodule

// File: rtl/pcm_frame_align.sv
// Top of the PCM frame alignment counter for one side of the link.
// Assumes all inputs are synchronous to clk; data storage lives elsewhere.
module pcm_frame_align
    import pfa_pkg::*;
#(
    parameter int BITS_PER_CHAN = 8,
    parameter int T1_CHANNELS   = 24,
    parameter int CEPT_CHANNELS = 32,
    localparam int MAX_CH = (T1_CHANNELS > CEPT_CHANNELS) ? T1_CHANNELS : CEPT_CHANNELS,
    localparam int BIT_W  = $clog2(BITS_PER_CHAN),
    localparam int CH_W   = $clog2(MAX_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_sync,
    input  logic             fmt_sel,
    input  logic             peer_fmt_sel,
    input  logic             peer_fbit,
    output logic [BIT_W-1:0] bit_idx,
    output logic [CH_W-1:0]  chan_idx,
    output logic             frame_start,
    output logic             fbit_slot,
    output logic             fbit_out,
    output logic             fmt_active
);
    logic rise;
    fmt_e act;

    pfa_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (frame_sync),
        .rise    (rise)
    );

    pfa_frame_counter #(
        .BITS_PER_CHAN (BITS_PER_CHAN),
        .T1_CHANNELS   (T1_CHANNELS),
        .CEPT_CHANNELS (CEPT_CHANNELS),
        .BIT_W         (BIT_W),
        .CH_W          (CH_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .realign  (rise),
        .fmt_req  (fmt_e'(fmt_sel)),
        .bit_idx  (bit_idx),
        .chan_idx (chan_idx),
        .in_fslot (fbit_slot),
        .fmt_act  (act)
    );

    pfa_slot_out #(
        .BIT_W (BIT_W),
        .CH_W  (CH_W)
    ) u_out (
        .bit_idx     (bit_idx),
        .chan_idx    (chan_idx),
        .in_fslot    (fbit_slot),
        .fmt_act     (act),
        .peer_fmt    (fmt_e'(peer_fmt_sel)),
        .peer_fbit   (peer_fbit),
        .frame_start (frame_start),
        .fbit_out    (fbit_out)
    );

    // Present the active format as a plain bit.
    always_comb fmt_active = act;
endmodule

// File: rtl/pfa_frame_align_chk.sv
// Assertion checker for pcm_frame_align, attached by bind below.
// Assumes the default channel layout sizes unless overridden through the bind.
module pfa_frame_align_chk #(
    parameter int T1_CHANNELS = 24,
    parameter int BIT_W       = 3,
    parameter int CH_W        = 5,
    parameter int BITS_PER_CHAN = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_sync,
    input logic             peer_fmt_sel,
    input logic             peer_fbit,
    input logic [BIT_W-1:0] bit_idx,
    input logic [CH_W-1:0]  chan_idx,
    input logic             frame_start,
    input logic             fbit_slot,
    input logic             fbit_out,
    input logic             fmt_active
);
    // R2
    sync_rise_starts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_sync) && !$past(frame_sync, 2)) |=> (frame_start && chan_idx == '0 && bit_idx == '0));

    // R4
    fslot_is_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fbit_slot |-> (frame_start && chan_idx == '0 && bit_idx == '0));

    // R4
    t1_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_active) |-> (int'(chan_idx) < T1_CHANNELS));

    // R4
    bit_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != BIT_W'(BITS_PER_CHAN - 1) && !fbit_slot && !(frame_sync && !$past(frame_sync)))
        |=> (bit_idx == BIT_W'($past(bit_idx) + 1'b1)) || frame_start);

    // R5
    cept_no_fslot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_active |-> !fbit_slot);

    // R8
    fmt_changes_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fmt_active) |-> frame_start);

    // R9
    fbit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fbit_slot |-> !fbit_out);

    // R9
    fbit_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_slot && peer_fmt_sel) |-> fbit_out);

    // R9
    fbit_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fbit_slot && !peer_fmt_sel) |-> (fbit_out == peer_fbit));
endmodule

bind pcm_frame_align pfa_frame_align_chk #(
    .T1_CHANNELS   (T1_CHANNELS),
    .BIT_W         (BIT_W),
    .CH_W          (CH_W),
    .BITS_PER_CHAN (BITS_PER_CHAN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync   (frame_sync),
    .peer_fmt_sel (peer_fmt_sel),
    .peer_fbit    (peer_fbit),
    .bit_idx      (bit_idx),
    .chan_idx     (chan_idx),
    .frame_start  (frame_start),
    .fbit_slot    (fbit_slot),
    .fbit_out     (fbit_out),
    .fmt_active   (fmt_active)
);

// File: tb/sim_pcm_frame_align.sv
// Bench for pcm_frame_align: behavioural position model compared every clock,
// plus directed checks on latency, flywheel period, format switching and F-bit.
module sim_pcm_frame_align;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_sync;
    logic       fmt_sel;
    logic       peer_fmt_sel;
    logic       peer_fbit;
    logic [2:0] bit_idx;
    logic [4:0] chan_idx;
    logic       frame_start;
    logic       fbit_slot;
    logic       fbit_out;
    logic       fmt_active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcm_frame_align u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_sync   (frame_sync),
        .fmt_sel      (fmt_sel),
        .peer_fmt_sel (peer_fmt_sel),
        .peer_fbit    (peer_fbit),
        .bit_idx      (bit_idx),
        .chan_idx     (chan_idx),
        .frame_start  (frame_start),
        .fbit_slot    (fbit_slot),
        .fbit_out     (fbit_out),
        .fmt_active   (fmt_active)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: frame position as an integer plus the active layout.
    int m_pos = 0;
    int m_act = 0;
    int m_s1  = 0;
    int m_s2  = 0;

    function automatic int frame_len(input int f);
        return (f != 0) ? 256 : 193;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_act = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            bit rose;
            rose = (m_s1 == 1) && (m_s2 == 0);
            m_s2 = m_s1;
            m_s1 = int'(frame_sync);
            if (rose || m_pos == frame_len(m_act) - 1) begin
                m_pos = 0;
                m_act = int'(fmt_sel);
            end else begin
                m_pos++;
            end
        end
    end

    // Compare the model with the outputs shortly after every clock edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int e_ch, e_bit, e_fs, e_fo;
            string rq;
            if (m_act == 0) begin
                rq    = "R4";
                e_fs  = (m_pos == 0) ? 1 : 0;
                e_ch  = (m_pos == 0) ? 0 : (m_pos - 1) / 8;
                e_bit = (m_pos == 0) ? 0 : (m_pos - 1) % 8;
            end else begin
                rq    = "R5";
                e_fs  = 0;
                e_ch  = m_pos / 8;
                e_bit = m_pos % 8;
            end
            e_fo = (e_fs == 1) ? (peer_fmt_sel ? 1 : int'(peer_fbit)) : 0;
            chk(int'(chan_idx) == e_ch, rq, "chan_idx", chan_idx, e_ch);
            chk(int'(bit_idx) == e_bit, rq, "bit_idx", bit_idx, e_bit);
            chk(int'(fbit_slot) == e_fs, rq, "fbit_slot", fbit_slot, e_fs);
            chk(int'(frame_start) == ((m_pos == 0) ? 1 : 0), "R10", "frame_start", frame_start, (m_pos == 0) ? 1 : 0);
            chk(int'(fmt_active) == m_act, "R8", "fmt_active", fmt_active, m_act);
            chk(int'(fbit_out) == e_fo, "R9", "fbit_out", fbit_out, e_fo);
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!frame_start);
    endtask

    task automatic measure(output int n);
        wait_start();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_start && n < 1000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int p;
        rst_n = 1'b0; frame_sync = 1'b0; fmt_sel = 1'b0;
        peer_fmt_sel = 1'b0; peer_fbit = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(frame_start && fbit_slot && chan_idx == 0 && bit_idx == 0 && !fmt_active,
            "R1", "reset position", {frame_start, fbit_slot, fmt_active}, 3'b110);
        rst_n = 1'b1;
        #1;
        chk(frame_start && fbit_slot, "R1", "after release", {frame_start, fbit_slot}, 2'b11);

        // R6: free run with no sync at all
        measure(p);
        chk(p == 193, "R6", "193-bit period", p, 193);

        // R2 / R7: single pulse mid-frame
        repeat (50) @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        chk(!frame_start, "R2", "one edge early", frame_start, 0);
        @(negedge clk);
        chk(frame_start && fbit_slot && chan_idx == 0 && bit_idx == 0, "R7", "realign", frame_start, 1);
        @(negedge clk);
        chk(chan_idx == 0 && bit_idx == 0 && !fbit_slot, "R4", "channel 0 after F slot", chan_idx, 0);

        // R6: flywheel after a single pulse
        measure(p);
        chk(p == 193, "R6", "period after pulse", p, 193);

        // R3: held-high sync is one edge only
        repeat (30) @(negedge clk);
        frame_sync = 1'b1;
        repeat (5) @(negedge clk);
        measure(p);
        chk(p == 193, "R3", "period with sync held", p, 193);
        measure(p);
        chk(p == 193, "R3", "second period with sync held", p, 193);
        frame_sync = 1'b0;

        // R9: framing bit forwarding and forcing
        wait_start();
        peer_fbit = 1'b1;
        #1;
        chk(fbit_out == 1'b1, "R9", "forward 1", fbit_out, 1);
        peer_fbit = 1'b0;
        #1;
        chk(fbit_out == 1'b0, "R9", "forward 0", fbit_out, 0);
        peer_fmt_sel = 1'b1;
        #1;
        chk(fbit_out == 1'b1, "R9", "forced 1", fbit_out, 1);
        @(negedge clk);
        chk(fbit_out == 1'b0, "R9", "outside slot", fbit_out, 0);
        peer_fmt_sel = 1'b0;

        // R8: format change mid-frame waits for the wrap
        repeat (20) @(negedge clk);
        fmt_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk(fmt_active == 1'b0, "R8", "no switch mid-frame", fmt_active, 0);
        wait_start();
        chk(fmt_active == 1'b1 && !fbit_slot, "R8", "switch at wrap", fmt_active, 1);
        measure(p);
        chk(p == 256, "R5", "256-bit period", p, 256);

        // R7: realign in the 256-bit format
        repeat (77) @(negedge clk);
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        @(negedge clk);
        chk(frame_start && chan_idx == 0 && bit_idx == 0 && fmt_active, "R7", "realign 256", frame_start, 1);
        measure(p);
        chk(p == 256, "R6", "256 flywheel", p, 256);

        // R8: format change taken at a sync edge
        repeat (40) @(negedge clk);
        fmt_sel = 1'b0;
        frame_sync = 1'b1;
        @(negedge clk);
        frame_sync = 1'b0;
        chk(fmt_active == 1'b1, "R8", "still 256 before edge", fmt_active, 1);
        @(negedge clk);
        chk(fmt_active == 1'b0 && fbit_slot, "R8", "switch at sync", fmt_active, 0);
        measure(p);
        chk(p == 193, "R4", "back to 193", p, 193);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule